// File: doc/BRIEF.md
# Multi-phase RAM test engine

This block is a built-in self-test controller for a byte-wide synchronous RAM port. On a start pulse it captures a region, given as a 16-bit base address and a 16-bit byte count, and walks it in four passes. Each pass fills the region first and then sweeps it again to read each byte back and compare it with the value that should be there. The first two passes show whether every bit can hold both levels. The last two store address-derived values, which exposes aliased, open or shorted address lines and chip-select faults.

Before the read-back of each address pass, the engine leaves the RAM untouched for a fixed number of clock cycles. If refresh has failed, the stored data has time to decay, so the read sweep itself does not keep the cells alive. The engine stops at the first pass that fails. It reports a code naming that pass, the address of the first wrong byte and the length of the contiguous run of wrong bytes that starts there. The results stay on the outputs until the next start.

Top module: `ramtest_engine`

## Requirements
- R1: The passes run in this fixed order, and each writes one value to every byte of the region. Pass 0 writes 55h, pass 1 writes AAh, pass 2 writes bits [7:0] of the byte's own address, and pass 3 writes bits [15:8] of that address.
- R2: Within each pass, every byte is written once in ascending address order from base to base+len-1, and only then is every byte read once in the same order. No access falls outside the region. Read data is taken one cycle after the read is issued.
- R3: When `done_o` is high, `code_o` is 00h if all four passes match. Otherwise it names the failing pass: 55h for pass 0, AAh for pass 1, 01h for pass 2 and 02h for pass 3.
- R4: On a failure, `fail_addr_o` holds the lowest address whose read-back differed from the expected value in the failing pass. `fail_len_o` counts the wrong bytes in the unbroken run that starts there, up to the first matching byte or the end of the region. On success, both are zero.
- R5: Testing stops after the first failing pass. No later pass issues any write, and the RAM port is idle whenever `busy_o` is low.
- R6: In passes 2 and 3 only, exactly RETAIN_CYC cycles with no RAM access separate the last write from the first read. In passes 0 and 1 the first read follows the last write immediately.
- R7: A start with a length of zero raises `done_o` one cycle later with code 00h and zero fault fields, and makes no RAM access.
- R8: `start_i` is taken only while the engine is not busy. It is ignored while `busy_o` is high. Taking a start clears `done_o` on the next edge. `done_o` and the result outputs hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| base_i | input | 16 | First address of the region |
| len_i | input | 16 | Number of bytes to test; base+len must not exceed FFFFh |
| busy_o | output | 1 | High while a test is running |
| done_o | output | 1 | High from completion until the next accepted start |
| code_o | output | 8 | Result code (00h pass, 55h, AAh, 01h, 02h) |
| fail_addr_o | output | 16 | Address of the first wrong byte |
| fail_len_o | output | 16 | Length of the first run of wrong bytes |
| mem_en_o | output | 1 | RAM access enable |
| mem_we_o | output | 1 | RAM write enable (read when low) |
| mem_addr_o | output | 16 | RAM address |
| mem_wdata_o | output | 8 | RAM write data |
| mem_rdata_i | input | 8 | RAM read data, valid one cycle after a read |

## Verification
The region check in the assertions assumes a legal region, meaning the base plus the length never passes FFFFh. It also assumes the RAM returns read data exactly one cycle after the read. The bench model honours that latency, and every region it requests lies well inside a 4 KiB window. Faults are injected only inside the model: stuck bits over an address range, ignored address bits, and wiping of the whole array after a quiet stretch longer than the model tolerates but shorter than the retention wait. The engine therefore always sees a legal port.

// File: rtl/ramtest_pkg.sv
package ramtest_pkg;

  typedef enum logic [1:0] {
    PASS_P55 = 2'd0,
    PASS_PAA = 2'd1,
    PASS_LO  = 2'd2,
    PASS_HI  = 2'd3
  } pass_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_HOLD,
    ST_READ,
    ST_DRAIN,
    ST_EVAL
  } seq_st_t;

endpackage

// File: rtl/ramtest_chk.sv
// Read-back comparator: aligns each issued read with the data returned one
// cycle later and tracks the first contiguous run of mismatching bytes.
module ramtest_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              iss_i,
  input  logic [ADDR_W-1:0] iss_addr_i,
  input  logic [DATA_W-1:0] iss_exp_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              bad_seen_o,
  output logic              run_open_o,
  output logic [ADDR_W-1:0] first_addr_o,
  output logic [ADDR_W-1:0] run_len_o
);

  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] exp_q;
  logic              miss;

  assign miss = vld_q && (rdata_i != exp_q);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      exp_q  <= '0;
    end else begin
      vld_q  <= iss_i;
      addr_q <= iss_addr_i;
      exp_q  <= iss_exp_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      bad_seen_o   <= 1'b0;
      run_open_o   <= 1'b0;
      first_addr_o <= '0;
      run_len_o    <= '0;
    end else if (vld_q) begin
      if (miss) begin
        if (!bad_seen_o) begin
          bad_seen_o   <= 1'b1;
          run_open_o   <= 1'b1;
          first_addr_o <= addr_q;
          run_len_o    <= ADDR_W'(1);
        end else if (run_open_o) begin
          run_len_o <= run_len_o + ADDR_W'(1);
        end
      end else if (run_open_o) begin
        run_open_o <= 1'b0;
      end
    end
  end

  // R4: a recorded run is never empty
  p_run_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    bad_seen_o |-> (run_len_o != '0));

  // R4: an open run implies a first failure was captured
  p_open_has_bad_r4: assert property (@(posedge clk) disable iff (rst)
    run_open_o |-> bad_seen_o);

  // R4: once captured, the first failing address does not move within a pass
  p_first_fixed_r4: assert property (@(posedge clk) disable iff (rst)
    (bad_seen_o && !clr_i) |=> $stable(first_addr_o));

  // R4: a closed run never grows again
  p_closed_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (bad_seen_o && !run_open_o && !clr_i) |=> $stable(run_len_o));

endmodule

// File: rtl/ramtest_seq.sv
// Pass sequencer: write sweep, optional retention wait, read sweep, evaluate.
module ramtest_seq
  import ramtest_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int RETAIN_CYC = 375_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] len_i,
  input  logic              bad_seen_i,
  input  logic              run_open_i,
  output logic              busy_o,
  output logic              accept_o,
  output logic              finish_o,
  output logic              fin_bad_o,
  output pass_t             fin_pass_o,
  output logic              clr_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              iss_o,
  output logic [DATA_W-1:0] iss_exp_o
);

  localparam bit HOLD_ON   = (RETAIN_CYC > 0);
  localparam int CNT_W     = (RETAIN_CYC > 1) ? $clog2(RETAIN_CYC) : 1;
  localparam int HOLD_LAST = (RETAIN_CYC > 0) ? RETAIN_CYC - 1 : 0;

  seq_st_t           state_q;
  pass_t             pass_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] len_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] remain_q;
  logic [CNT_W-1:0]  hold_q;
  logic [1:0]        pass_nxt;
  logic              bad_closed;
  logic              last_beat;
  logic              addr_pass;
  logic [DATA_W-1:0] pat;

  function automatic logic [DATA_W-1:0] pattern(pass_t p, logic [ADDR_W-1:0] a);
    case (p)
      PASS_P55: return {(DATA_W/2){2'b01}};
      PASS_PAA: return {(DATA_W/2){2'b10}};
      PASS_LO:  return a[DATA_W-1:0];
      default:  return a[2*DATA_W-1:DATA_W];
    endcase
  endfunction

  assign pat        = pattern(pass_q, addr_q);
  assign pass_nxt   = pass_q + 2'd1;
  assign bad_closed = bad_seen_i && !run_open_i;
  assign last_beat  = (remain_q == ADDR_W'(1));
  assign addr_pass  = (pass_q == PASS_LO) || (pass_q == PASS_HI);

  assign busy_o      = (state_q != ST_IDLE);
  assign accept_o    = (state_q == ST_IDLE) && start_i;
  assign mem_en_o    = (state_q == ST_WRITE) || (state_q == ST_READ);
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = pat;
  assign iss_o       = (state_q == ST_READ);
  assign iss_exp_o   = pat;
  assign fin_bad_o   = busy_o && bad_seen_i;
  assign fin_pass_o  = pass_q;

  always_comb begin
    finish_o = 1'b0;
    case (state_q)
      ST_IDLE:           finish_o = start_i && (len_i == '0);
      ST_READ, ST_DRAIN: finish_o = bad_closed;
      ST_EVAL:           finish_o = bad_seen_i || (pass_q == PASS_HI);
      default:           finish_o = 1'b0;
    endcase
  end

  assign clr_o = accept_o || ((state_q == ST_EVAL) && !finish_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      pass_q   <= PASS_P55;
      base_q   <= '0;
      len_q    <= '0;
      addr_q   <= '0;
      remain_q <= '0;
      hold_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            base_q   <= base_i;
            len_q    <= len_i;
            addr_q   <= base_i;
            remain_q <= len_i;
            pass_q   <= PASS_P55;
            if (len_i != '0) state_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          hold_q <= '0;
          if (last_beat) begin
            addr_q   <= base_q;
            remain_q <= len_q;
            state_q  <= (HOLD_ON && addr_pass) ? ST_HOLD : ST_READ;
          end else begin
            addr_q   <= addr_q + ADDR_W'(1);
            remain_q <= remain_q - ADDR_W'(1);
          end
        end
        ST_HOLD: begin
          hold_q <= hold_q + CNT_W'(1);
          if (hold_q == CNT_W'(HOLD_LAST)) state_q <= ST_READ;
        end
        ST_READ: begin
          if (bad_closed) begin
            state_q <= ST_IDLE;
          end else if (last_beat) begin
            state_q <= ST_DRAIN;
          end else begin
            addr_q   <= addr_q + ADDR_W'(1);
            remain_q <= remain_q - ADDR_W'(1);
          end
        end
        ST_DRAIN: begin
          state_q <= bad_closed ? ST_IDLE : ST_EVAL;
        end
        ST_EVAL: begin
          if (finish_o) begin
            state_q <= ST_IDLE;
          end else begin
            pass_q   <= pass_t'(pass_nxt);
            addr_q   <= base_q;
            remain_q <= len_q;
            state_q  <= ST_WRITE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: every access stays inside the captured region
  p_addr_in_region_r2: assert property (@(posedge clk) disable iff (rst)
    mem_en_o |-> ((addr_q >= base_q) &&
                  ({1'b0, addr_q} < ({1'b0, base_q} + {1'b0, len_q}))));

  // R6: the retention wait only occurs in the address passes
  p_hold_addr_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD) |-> addr_pass);

  // R2: a read sweep starts at the region base
  p_read_from_base_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READ && $past(state_q) != ST_READ) |-> (addr_q == base_q));

endmodule

// File: rtl/ramtest_engine.sv
module ramtest_engine
  import ramtest_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int RETAIN_CYC = 375_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] code_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [ADDR_W-1:0] fail_len_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  localparam logic [DATA_W-1:0] CODE_OK  = '0;
  localparam logic [DATA_W-1:0] CODE_P55 = {(DATA_W/2){2'b01}};
  localparam logic [DATA_W-1:0] CODE_PAA = {(DATA_W/2){2'b10}};
  localparam logic [DATA_W-1:0] CODE_LO  = DATA_W'(1);
  localparam logic [DATA_W-1:0] CODE_HI  = DATA_W'(2);

  logic              accept, finish, fin_bad, clr;
  pass_t             fin_pass;
  logic              iss;
  logic [DATA_W-1:0] iss_exp;
  logic              bad_seen, run_open;
  logic [ADDR_W-1:0] first_addr, run_len;
  logic [DATA_W-1:0] fail_code;

  always_comb begin
    case (fin_pass)
      PASS_P55: fail_code = CODE_P55;
      PASS_PAA: fail_code = CODE_PAA;
      PASS_LO:  fail_code = CODE_LO;
      default:  fail_code = CODE_HI;
    endcase
  end

  ramtest_seq #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .RETAIN_CYC(RETAIN_CYC)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .base_i     (base_i),
    .len_i      (len_i),
    .bad_seen_i (bad_seen),
    .run_open_i (run_open),
    .busy_o     (busy_o),
    .accept_o   (accept),
    .finish_o   (finish),
    .fin_bad_o  (fin_bad),
    .fin_pass_o (fin_pass),
    .clr_o      (clr),
    .mem_en_o   (mem_en_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .iss_o      (iss),
    .iss_exp_o  (iss_exp)
  );

  ramtest_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clr_i       (clr),
    .iss_i       (iss),
    .iss_addr_i  (mem_addr_o),
    .iss_exp_i   (iss_exp),
    .rdata_i     (mem_rdata_i),
    .bad_seen_o  (bad_seen),
    .run_open_o  (run_open),
    .first_addr_o(first_addr),
    .run_len_o   (run_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o      <= 1'b0;
      code_o      <= CODE_OK;
      fail_addr_o <= '0;
      fail_len_o  <= '0;
    end else if (finish) begin
      done_o      <= 1'b1;
      code_o      <= fin_bad ? fail_code : CODE_OK;
      fail_addr_o <= fin_bad ? first_addr : '0;
      fail_len_o  <= fin_bad ? run_len : '0;
    end else if (accept) begin
      done_o <= 1'b0;
    end
  end

  // R8: results hold while no new start arrives
  p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> (done_o && $stable(code_o) &&
                              $stable(fail_addr_o) && $stable(fail_len_o)));

  // R8: done and busy never overlap
  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  // R3: only the five defined codes appear
  p_code_legal_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (code_o == CODE_OK || code_o == CODE_P55 || code_o == CODE_PAA ||
                code_o == CODE_LO || code_o == CODE_HI));

  // R4: a passing result carries empty fault fields
  p_clean_fields_r4: assert property (@(posedge clk) disable iff (rst)
    (done_o && code_o == CODE_OK) |-> (fail_addr_o == '0 && fail_len_o == '0));

  // R5: the RAM port is quiet whenever the engine is idle
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !mem_en_o);

endmodule

// File: tb/sim_ramtest_engine.sv
`timescale 1ns/1ps
module sim_ramtest_engine;

  localparam int RETAIN = 24;
  localparam int DECAY  = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] base_i = '0;
  logic [15:0] len_i = '0;
  logic        busy_o, done_o;
  logic [7:0]  code_o;
  logic [15:0] fail_addr_o, fail_len_o;
  logic        mem_en_o, mem_we_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;

  always #4 clk = ~clk;

  ramtest_engine #(.ADDR_W(16), .DATA_W(8), .RETAIN_CYC(RETAIN)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .len_i(len_i),
    .busy_o(busy_o), .done_o(done_o), .code_o(code_o),
    .fail_addr_o(fail_addr_o), .fail_len_o(fail_len_o),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  int checks = 0;
  int errors = 0;

  // ---------------- RAM model with fault injection ----------------
  logic [7:0]  mem [0:4095];
  logic [15:0] alias_m = '0;
  logic [7:0]  stk0 = '0, stk1 = '0;
  logic [15:0] stk_lo = 16'hFFFF, stk_hi = 16'h0000;
  logic        decay_en = 1'b0;
  int          idle_cnt = 0;

  always @(posedge clk) begin
    if (mem_en_o) begin
      logic [15:0] phys;
      logic [7:0]  wv;
      phys = mem_addr_o & ~alias_m;
      wv = mem_wdata_o;
      if (mem_addr_o >= stk_lo && mem_addr_o <= stk_hi) wv = (wv & ~stk0) | stk1;
      if (mem_we_o) mem[phys[11:0]] <= wv;
      else mem_rdata_i <= mem[phys[11:0]];
      idle_cnt <= 0;
    end else begin
      idle_cnt <= idle_cnt + 1;
      if (decay_en && idle_cnt == DECAY)
        for (int i = 0; i < 4096; i++) mem[i] <= 8'h00;
    end
  end

  // ---------------- port monitor ----------------
  int          mon_len = 0;
  logic [15:0] mon_base = '0;
  int          wr_cnt = 0, rd_cnt = 0, mon_err = 0, gap = 0;
  int          gaps [4];

  function automatic logic [7:0] exp_pat(int p, logic [15:0] a);
    case (p)
      0: return 8'h55;
      1: return 8'hAA;
      2: return a[7:0];
      default: return a[15:8];
    endcase
  endfunction

  always @(negedge clk) begin
    if (mem_en_o) begin
      if (mon_len > 0) begin
        if (mem_we_o) begin
          int p, k;
          p = wr_cnt / mon_len; k = wr_cnt % mon_len;
          if (p > 3 || mem_addr_o != mon_base + 16'(k) ||
              mem_wdata_o != exp_pat(p, mem_addr_o) || rd_cnt != p * mon_len)
            mon_err++;
          wr_cnt++;
        end else begin
          int p, k;
          p = rd_cnt / mon_len; k = rd_cnt % mon_len;
          if (p > 3 || mem_addr_o != mon_base + 16'(k) || wr_cnt != (p + 1) * mon_len)
            mon_err++;
          if (k == 0 && p < 4) gaps[p] = gap;
          rd_cnt++;
        end
      end
      gap = 0;
    end else begin
      gap++;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_faults();
    alias_m = '0; stk0 = '0; stk1 = '0;
    stk_lo = 16'hFFFF; stk_hi = 16'h0000; decay_en = 1'b0;
  endtask

  task automatic arm(logic [15:0] b, logic [15:0] l);
    mon_base = b; mon_len = l; wr_cnt = 0; rd_cnt = 0; mon_err = 0;
    for (int i = 0; i < 4; i++) gaps[i] = -1;
  endtask

  task automatic kick(logic [15:0] b, logic [15:0] l);
    @(negedge clk);
    base_i = b; len_i = l; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!done_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (!done_o) begin
      checks++; errors++;
      $display("FAIL R8 done never rose: actual 0 expected 1");
    end
  endtask

  task automatic run_case(logic [15:0] b, logic [15:0] l);
    arm(b, l);
    kick(b, l);
    wait_done();
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check("R8", "busy after reset", int'(busy_o), 0);
    check("R8", "done after reset", int'(done_o), 0);
    check("R3", "code after reset", int'(code_o), 0);
    check("R5", "mem_en after reset", int'(mem_en_o), 0);
  endtask

  task automatic t_zero_len();
    arm(16'h0100, 0);
    kick(16'h0100, 16'h0000);
    check("R7", "done one cycle after zero-length start", int'(done_o), 1);
    check("R7", "code for zero length", int'(code_o), 0);
    check("R7", "fail_len for zero length", int'(fail_len_o), 0);
    check("R7", "writes for zero length", wr_cnt, 0);
  endtask

  task automatic t_clean();
    clear_faults();
    arm(16'h0100, 40);
    kick(16'h0100, 16'd40);
    check("R8", "done cleared after start", int'(done_o), 0);
    check("R8", "busy after start", int'(busy_o), 1);
    wait_done();
    check("R3", "clean code", int'(code_o), 0);
    check("R4", "clean fail_addr", int'(fail_addr_o), 0);
    check("R4", "clean fail_len", int'(fail_len_o), 0);
    check("R1", "clean write count", wr_cnt, 160);
    check("R2", "clean read count", rd_cnt, 160);
    check("R1", "order/pattern errors", mon_err, 0);
    check("R6", "gap pass 0", gaps[0], 0);
    check("R6", "gap pass 1", gaps[1], 0);
    check("R6", "gap pass 2", gaps[2], RETAIN);
    check("R6", "gap pass 3", gaps[3], RETAIN);
  endtask

  task automatic t_bit_55();
    clear_faults();
    stk_lo = 16'h0105; stk_hi = 16'h0105; stk0 = 8'h01;
    run_case(16'h0100, 16'd40);
    check("R3", "55 pass fail code", int'(code_o), 8'h55);
    check("R4", "55 fail address", int'(fail_addr_o), 16'h0105);
    check("R4", "55 run length", int'(fail_len_o), 1);
    check("R5", "no writes after failing pass 0", wr_cnt, 40);
    check("R2", "sweep order", mon_err, 0);
  endtask

  task automatic t_run_aa();
    clear_faults();
    stk_lo = 16'h0203; stk_hi = 16'h0206; stk1 = 8'h01;
    run_case(16'h0200, 16'd32);
    check("R3", "AA pass fail code", int'(code_o), 8'hAA);
    check("R4", "AA fail address", int'(fail_addr_o), 16'h0203);
    check("R4", "AA run length", int'(fail_len_o), 4);
    check("R5", "no writes after failing pass 1", wr_cnt, 64);
  endtask

  task automatic t_low_alias();
    clear_faults();
    alias_m = 16'h0004;
    run_case(16'h0300, 16'd16);
    check("R3", "low pass fail code", int'(code_o), 1);
    check("R4", "low fail address", int'(fail_addr_o), 16'h0300);
    check("R4", "low run length", int'(fail_len_o), 4);
    check("R5", "no writes after failing pass 2", wr_cnt, 48);
  endtask

  task automatic t_high_alias();
    clear_faults();
    alias_m = 16'h0100;
    run_case(16'h0200, 16'h0110);
    check("R3", "high pass fail code", int'(code_o), 2);
    check("R4", "high fail address", int'(fail_addr_o), 16'h0200);
    check("R4", "high run length", int'(fail_len_o), 16);
    check("R1", "high pass order", mon_err, 0);
  endtask

  task automatic t_decay();
    clear_faults();
    decay_en = 1'b1;
    run_case(16'h0401, 16'd8);
    check("R6", "retention loss code", int'(code_o), 1);
    check("R6", "retention loss address", int'(fail_addr_o), 16'h0401);
    check("R4", "run to region end", int'(fail_len_o), 8);
    clear_faults();
  endtask

  task automatic t_start_busy();
    clear_faults();
    arm(16'h0100, 40);
    kick(16'h0100, 16'd40);
    repeat (10) @(negedge clk);
    base_i = 16'h0105; len_i = 16'd3; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    check("R8", "start ignored while busy: code", int'(code_o), 0);
    check("R8", "start ignored while busy: writes", wr_cnt, 160);
    check("R8", "start ignored while busy: order", mon_err, 0);
  endtask

  task automatic t_hold_result();
    logic [7:0]  c;
    logic [15:0] a, l;
    clear_faults();
    stk_lo = 16'h0203; stk_hi = 16'h0206; stk1 = 8'h01;
    run_case(16'h0200, 16'd32);
    c = code_o; a = fail_addr_o; l = fail_len_o;
    clear_faults();
    repeat (20) @(negedge clk);
    check("R8", "done held", int'(done_o), 1);
    check("R8", "code held", int'(code_o), int'(c));
    check("R8", "fail_addr held", int'(fail_addr_o), int'(a));
    check("R8", "fail_len held", int'(fail_len_o), int'(l));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero_len();
    t_clean();
    t_bit_55();
    t_run_aa();
    t_low_alias();
    t_high_alias();
    t_decay();
    t_start_busy();
    t_hold_result();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R8 watchdog expired: actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule